// File: doc/BRIEF.md
# UART Modem-Control Loopback Unit

This unit sits between a UART's register interface and its receive queue and implements internal loopback. While loopback is on, software's modem-control outputs are reflected straight onto the modem status flags, and the modem-status interrupt bits are recomputed from those flags. Characters written to the transmit data register and rising send-break requests are turned into receive-queue entries instead of leaving on the line.

While loopback is off, the unit passes characters and break events from the external line to the receive queue. It leaves the modem status flags exactly as they were. Every receive-queue entry is a data byte plus one break-marker bit. A push is withheld whenever the queue reports full in the requesting cycle. At most one entry is pushed per cycle.

All outputs are registered. A request presented in one clock cycle shows up on the outputs after the next rising edge.

Top module: `uart_mdm_loopback`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge), st_flags, ms_irq and push_valid are all zero, and loopback is off.
- R2: A control write whose bit 0 (loop enable) is 1 sets st_flags[3] (ring indicate) to control bit 4 (Out2) and st_flags[2] (carrier detect) to control bit 3 (Out1), one cycle after the write.
- R3: The same write sets st_flags[0] (clear to send) to control bit 2 (request to send) and st_flags[1] (data set ready) to control bit 1 (data terminal ready).
- R4: On such a write, all four modem interrupt bits are cleared first. Each bit is then set where its flag in the new st_flags is 1, so ms_irq equals the new st_flags (same bit order) and a flag that drops also drops its interrupt bit.
- R5: A control write with bit 0 equal to 0 turns loopback off and leaves st_flags and ms_irq unchanged.
- R6: The mapping applies on the very write that turns loopback on, with no earlier loopback write needed.
- R7: In loopback, a data-register write pushes {1'b0, data} to the receive queue one cycle later.
- R8: In loopback, a line-control write with the break bit 1 while the stored break bit is 0 pushes {1'b1, 8'h00}. A write that keeps the break bit at 1, or clears it, pushes nothing. The stored break bit follows every line-control write in either mode.
- R9: In loopback, characters and break events from the external line push nothing.
- R10: Outside loopback, a line character pushes {1'b0, data} and a line break event pushes {1'b1, 8'h00}. Data-register writes and break-bit changes push nothing.
- R11: No push happens for a request made in a cycle when rxq_full is high.
- R12: When a character request and a break request from the active source occur in the same cycle, only the character is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control write value: [0] loop enable, [1] DTR, [2] RTS, [3] Out1, [4] Out2 |
| lcr_wr_en | input | 1 | Line-control register write strobe |
| lcr_brk | input | 1 | Send-break bit of the line-control write |
| dr_wr_en | input | 1 | Transmit data register write strobe |
| dr_wdata | input | 8 | Transmit data value |
| line_rx_valid | input | 1 | Character arrived from the external line |
| line_rx_data | input | 8 | Character from the external line |
| line_brk_evt | input | 1 | Break condition seen on the external line |
| rxq_full | input | 1 | Receive queue is full |
| st_flags | output | 4 | Modem status flags: [0] CTS, [1] DSR, [2] DCD, [3] RI |
| ms_irq | output | 4 | Modem-status interrupt bits, same order as st_flags |
| push_valid | output | 1 | Push request to the receive queue |
| push_entry | output | 9 | Entry to push: [8] break marker, [7:0] data |

## Verification
Every result is due exactly one rising edge after the stimulus: flag and interrupt updates after a control write, and receive-queue pushes after a data, line-control or line request. The driver applies each stimulus at a falling edge and compares st_flags and ms_irq at the next falling edge. Each expected push is queued with the cycle number in which it must appear. A monitor checks push_valid at every falling edge, so a push that is early, late, missing or not expected is reported, as well as one with the wrong content.

// File: rtl/uml_pkg.sv
// Shared constants for the modem-control loopback unit.
// Assumes a fixed control-word layout that the register decoder also uses.
package uml_pkg;
    localparam int CTL_W    = 5;
    localparam int CTL_LBE  = 0;
    localparam int CTL_DTR  = 1;
    localparam int CTL_RTS  = 2;
    localparam int CTL_OUT1 = 3;
    localparam int CTL_OUT2 = 4;

    localparam int FLAG_W   = 4;
    localparam int FLG_CTS  = 0;
    localparam int FLG_DSR  = 1;
    localparam int FLG_DCD  = 2;
    localparam int FLG_RI   = 3;

    // Control bit that drives each status flag in loopback
    function automatic int flag_src(input int flag_idx);
        case (flag_idx)
            FLG_CTS: return CTL_RTS;
            FLG_DSR: return CTL_DTR;
            FLG_DCD: return CTL_OUT1;
            default: return CTL_OUT2;
        endcase
    endfunction
endpackage

// File: rtl/uml_modem_map.sv
// Holds the loopback enable, the modem status flags and the modem interrupt
// bits. A control write with loop enable set maps the control outputs onto
// the flags and rebuilds the interrupt bits. A write with loop enable clear
// only turns loopback off.
// Assumes control writes arrive as single-cycle strobes.
module uml_modem_map
    import uml_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wr_data,
    output logic              loop_en,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] irq
);
    localparam logic [FLAG_W-1:0] MS_MASK = '1;

    logic [FLAG_W-1:0] mapped;
    logic [FLAG_W-1:0] irq_next;

    // Cross-map each control output onto its status flag
    for (genvar g = 0; g < FLAG_W; g++) begin : g_map
        assign mapped[g] = wr_data[flag_src(g)];
    end

    // Clear every modem interrupt bit, then set those whose flag is high
    always_comb begin
        irq_next = (irq & ~MS_MASK) | (mapped & MS_MASK);
    end

    // Register the loop enable, the flags and the interrupt bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_en <= 1'b0;
            flags   <= '0;
            irq     <= '0;
        end else if (wr_en) begin
            loop_en <= wr_data[CTL_LBE];
            if (wr_data[CTL_LBE]) begin
                flags <= mapped;
                irq   <= irq_next;
            end
        end
    end
endmodule

// File: rtl/uml_push_sel.sv
// Picks the source of receive-queue pushes. In loopback the source is the
// data-register writes and rising send-break requests; otherwise it is the
// external line. A character wins over a break in the same cycle. Nothing
// is pushed while the queue is full.
// Assumes the strobes are single-cycle and that loop_en is registered state.
module uml_push_sel #(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            loop_en,
    input  logic            dr_wr_en,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic            lcr_wr_en,
    input  logic            lcr_brk,
    input  logic            line_rx_valid,
    input  logic [DATA_W-1:0] line_rx_data,
    input  logic            line_brk_evt,
    input  logic            rxq_full,
    output logic            push_valid,
    output logic [DATA_W:0] push_entry
);
    localparam int ENT_W = DATA_W + 1;

    logic              brk_q;
    logic              chr_req;
    logic              brk_req;
    logic [DATA_W-1:0] chr_data;
    logic [ENT_W-1:0]  next_entry;

    // Select the request sources for the current mode
    always_comb begin
        chr_req  = loop_en ? dr_wr_en : line_rx_valid;
        chr_data = loop_en ? dr_wdata : line_rx_data;
        brk_req  = loop_en ? (lcr_wr_en && lcr_brk && !brk_q) : line_brk_evt;
        next_entry = chr_req ? {1'b0, chr_data} : {1'b1, {DATA_W{1'b0}}};
    end

    // Track the stored send-break bit on every line-control write
    always_ff @(posedge clk) begin
        if (!rst_n)         brk_q <= 1'b0;
        else if (lcr_wr_en) brk_q <= lcr_brk;
    end

    // Register one push per cycle, dropped when the queue is full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_valid <= 1'b0;
            push_entry <= '0;
        end else begin
            push_valid <= (chr_req || brk_req) && !rxq_full;
            if ((chr_req || brk_req) && !rxq_full) push_entry <= next_entry;
        end
    end
endmodule

// File: rtl/uart_mdm_loopback.sv
// Top of the modem-control loopback unit: joins the modem mapping stage and
// the receive-queue push selector. All outputs are registered, one cycle
// after their request.
module uart_mdm_loopback #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_en,
    input  logic [4:0]        ctrl_wdata,
    input  logic              lcr_wr_en,
    input  logic              lcr_brk,
    input  logic              dr_wr_en,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic              line_rx_valid,
    input  logic [DATA_W-1:0] line_rx_data,
    input  logic              line_brk_evt,
    input  logic              rxq_full,
    output logic [3:0]        st_flags,
    output logic [3:0]        ms_irq,
    output logic              push_valid,
    output logic [DATA_W:0]   push_entry
);
    logic loop_en;

    uml_modem_map u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr_en),
        .wr_data (ctrl_wdata),
        .loop_en (loop_en),
        .flags   (st_flags),
        .irq     (ms_irq)
    );

    uml_push_sel #(.DATA_W(DATA_W)) u_push (
        .clk           (clk),
        .rst_n         (rst_n),
        .loop_en       (loop_en),
        .dr_wr_en      (dr_wr_en),
        .dr_wdata      (dr_wdata),
        .lcr_wr_en     (lcr_wr_en),
        .lcr_brk       (lcr_brk),
        .line_rx_valid (line_rx_valid),
        .line_rx_data  (line_rx_data),
        .line_brk_evt  (line_brk_evt),
        .rxq_full      (rxq_full),
        .push_valid    (push_valid),
        .push_entry    (push_entry)
    );
endmodule

// File: rtl/uml_loopback_chk.sv
// Temporal checks for uart_mdm_loopback, attached with bind below.
module uml_loopback_chk #(
    parameter int DATA_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctrl_wr_en,
    input logic [4:0]      ctrl_wdata,
    input logic            lcr_wr_en,
    input logic            dr_wr_en,
    input logic            rxq_full,
    input logic            loop_en,
    input logic [3:0]      st_flags,
    input logic [3:0]      ms_irq,
    input logic            push_valid,
    input logic [DATA_W:0] push_entry
);
    a_r2_ri_dcd_map: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_en && ctrl_wdata[0]) |=>
        (st_flags[3] == $past(ctrl_wdata[4]) && st_flags[2] == $past(ctrl_wdata[3])));

    a_r3_cts_dsr_map: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_en && ctrl_wdata[0]) |=>
        (st_flags[0] == $past(ctrl_wdata[2]) && st_flags[1] == $past(ctrl_wdata[1])));

    a_r4_irq_rebuilt: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_en && ctrl_wdata[0]) |=> (ms_irq == st_flags));

    a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_en && !ctrl_wdata[0]) |=> ($stable(st_flags) && $stable(ms_irq)));

    a_r8_break_entry_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_entry[DATA_W]) |-> (push_entry[DATA_W-1:0] == '0));

    a_r9_line_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && !dr_wr_en && !lcr_wr_en) |=> !push_valid);

    a_r11_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_full |=> !push_valid);
endmodule

bind uart_mdm_loopback uml_loopback_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr_en (ctrl_wr_en),
    .ctrl_wdata (ctrl_wdata),
    .lcr_wr_en  (lcr_wr_en),
    .dr_wr_en   (dr_wr_en),
    .rxq_full   (rxq_full),
    .loop_en    (loop_en),
    .st_flags   (st_flags),
    .ms_irq     (ms_irq),
    .push_valid (push_valid),
    .push_entry (push_entry)
);

// File: tb/tb_uart_mdm_loopback.sv
module tb_uart_mdm_loopback;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr_en = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic       lcr_wr_en = 1'b0;
    logic       lcr_brk = 1'b0;
    logic       dr_wr_en = 1'b0;
    logic [7:0] dr_wdata = '0;
    logic       line_rx_valid = 1'b0;
    logic [7:0] line_rx_data = '0;
    logic       line_brk_evt = 1'b0;
    logic       rxq_full = 1'b0;
    logic [3:0] st_flags;
    logic [3:0] ms_irq;
    logic       push_valid;
    logic [8:0] push_entry;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [8:0] exp_q[$];
    int         due_q[$];
    string      tag_q[$];

    logic       loop_m = 1'b0;
    logic       brk_m  = 1'b0;
    logic [3:0] flags_m = '0;

    uart_mdm_loopback dut (.*);

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every push must match the head of the scoreboard in its due cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (push_valid) begin
                checks++;
                if (exp_q.size() == 0 || due_q[0] != cyc) begin
                    fails++;
                    $display("FAIL %s unexpected push: actual %h expected none",
                             (tag_q.size() != 0) ? tag_q[0] : "R9/R10/R11", push_entry);
                end else begin
                    if (push_entry !== exp_q[0]) begin
                        fails++;
                        $display("FAIL %s push entry: actual %h expected %h", tag_q[0], push_entry, exp_q[0]);
                    end
                    void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
                end
            end else if (exp_q.size() != 0 && due_q[0] == cyc) begin
                checks++; fails++;
                $display("FAIL %s missing push: actual none expected %h", tag_q[0], exp_q[0]);
                void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, record expected results, check flags
    task automatic drive(input string tag,
                         input logic cw, input logic [4:0] cd,
                         input logic lw, input logic lb,
                         input logic dw, input logic [7:0] dd,
                         input logic rv, input logic [7:0] rd, input logic rb,
                         input logic full);
        logic chr, brk;
        chr = loop_m ? dw : rv;
        brk = loop_m ? (lw && lb && !brk_m) : rb;
        if (!full && (chr || brk)) begin
            exp_q.push_back(chr ? {1'b0, (loop_m ? dd : rd)} : 9'h100);
            due_q.push_back(cyc + 1);
            tag_q.push_back(tag);
        end
        if (lw) brk_m = lb;
        if (cw) begin
            loop_m = cd[0];
            if (cd[0]) flags_m = {cd[4], cd[3], cd[1], cd[2]};
        end
        ctrl_wr_en = cw; ctrl_wdata = cd; lcr_wr_en = lw; lcr_brk = lb;
        dr_wr_en = dw; dr_wdata = dd; line_rx_valid = rv; line_rx_data = rd;
        line_brk_evt = rb; rxq_full = full;
        @(negedge clk);
        ctrl_wr_en = 0; lcr_wr_en = 0; dr_wr_en = 0; line_rx_valid = 0;
        line_brk_evt = 0; rxq_full = 0;
        check({tag, " flags"}, st_flags, flags_m);
        check({tag, " irq"}, ms_irq, flags_m);
        if (exp_q.size() == 0) check({tag, " no push"}, push_valid, 1'b0);
    endtask

    initial begin
        #(20 * 5000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset flags", st_flags, 4'h0);
        check("R1 reset irq", ms_irq, 4'h0);
        check("R1 reset push", push_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: control write with loopback off leaves flags alone
        drive("R5 off write", 1, 5'b10010, 0, 0, 0, 0, 0, 0, 0, 0);
        // R6: the enabling write itself applies the mapping
        drive("R6 enable write", 1, 5'b10011, 0, 0, 0, 0, 0, 0, 0, 0);
        // R4: dropped flags drop their interrupt bits
        drive("R4 remap", 1, 5'b01101, 0, 0, 0, 0, 0, 0, 0, 0);
        drive("R2 R3 all ones", 1, 5'b11111, 0, 0, 0, 0, 0, 0, 0, 0);
        drive("R5 disable", 1, 5'b00000, 0, 0, 0, 0, 0, 0, 0, 0);
        drive("R2 out2 only", 1, 5'b10001, 0, 0, 0, 0, 0, 0, 0, 0);
        drive("R3 rts only", 1, 5'b00101, 0, 0, 0, 0, 0, 0, 0, 0);
        // Loopback pushes
        drive("R7 dr write", 0, 0, 0, 0, 1, 8'hA5, 0, 0, 0, 0);
        drive("R7 dr write2", 0, 0, 0, 0, 1, 8'h00, 0, 0, 0, 0);
        drive("R9 line char", 0, 0, 0, 0, 0, 0, 1, 8'h3C, 0, 0);
        drive("R9 line break", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        drive("R8 break rise", 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        drive("R8 break hold", 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        drive("R8 break clear", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        drive("R8 break rise2", 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        drive("R8 break clear2", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        drive("R11 dr full", 0, 0, 0, 0, 1, 8'h77, 0, 0, 0, 1);
        drive("R11 break full", 0, 0, 1, 1, 0, 0, 0, 0, 0, 1);
        drive("R11 break kept", 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        drive("R11 clear", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        drive("R12 loop both", 0, 0, 1, 1, 1, 8'h42, 0, 0, 0, 0);
        drive("R12 clear", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // External line path
        drive("R10 loop off", 1, 5'b11110, 0, 0, 0, 0, 0, 0, 0, 0);
        drive("R10 line char", 0, 0, 0, 0, 0, 0, 1, 8'h5A, 0, 0);
        drive("R10 line break", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        drive("R10 dr ignored", 0, 0, 0, 0, 1, 8'h99, 0, 0, 0, 0);
        drive("R10 brk ignored", 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        drive("R12 line both", 0, 0, 0, 0, 0, 0, 1, 8'hC3, 1, 0);
        drive("R11 line full", 0, 0, 0, 0, 0, 0, 1, 8'h11, 1, 1);
        drive("R10 line char2", 0, 0, 0, 0, 0, 0, 1, 8'hFF, 0, 0);
        repeat (3) @(negedge clk);
        check("R7 R8 R10 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule